// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns a single start request into the sequence of column addresses that one SDRAM burst visits. It takes the starting column, a three-bit burst-length code, a wrap-order bit and a data-width selector. It then presents one column per clock, together with a valid strobe and a flag that marks the final beat. It sits between a command scheduler and the address pins. The scheduler fires a start pulse when it issues a read or write. The sequencer then supplies the column for every data beat of that access.

Bursts of 1, 2, 4 or 8 beats wrap inside an aligned block of that size. The order inside the block is either counting (sequential) or XOR (interleaved). A full-page burst instead walks the whole page and wraps at the page edge. It runs until it is stopped or restarted. The usable column width shrinks as the device data width grows. A write-single option cuts every write to one beat. A fresh start pulse on any clock drops the running burst and begins the new one at once.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, valid_o and last_o are low and col_o is zero.
- R2: The first beat appears on the outputs one clock after start_i is sampled. It shows start_col_i masked to the page width set by org_i. The widths are: 00 → 10 bits, 01 → 9 bits, 10 or 11 → 8 bits. Any bit above the page width reads as zero.
- R3: Sequential order (interleave_i = 0) works on the low log2(L) bits of the column, where L is the burst length. For beat i, those bits equal (start low bits + i) mod L. The bits above them stay at their start value.
- R4: Interleaved order (interleave_i = 1) with a fixed length gives beat i as the start column with its low log2(L) bits XORed with i.
- R5: bl_code_i selects the length: 000 → 1, 001 → 2, 010 → 4, 011 → 8, 111 → full page. The codes 100, 101 and 110 give length 1. A fixed-length burst holds valid_o high for exactly L consecutive beats, and valid_o is low on the clock after that.
- R6: last_o is high on the final beat of a fixed-length burst and on no other beat.
- R7: When write_i and single_write_i are both high at start, the burst has exactly one beat, whatever the length code. A read with single_write_i high keeps its programmed length.
- R8: A full-page burst increments the column by one per beat modulo the page width and ignores interleave_i. last_o stays low throughout.
- R9: stop_i sampled during a burst makes valid_o low on the next clock. If start_i and stop_i arrive on the same clock, the start wins.
- R10: start_i during a running burst aborts it. The next beat is the first beat of the new burst.
- R11: col_o reads zero whenever valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new burst (one-clock pulse) |
| stop_i | input | 1 | End the running burst |
| start_col_i | input | COL_W | Starting column |
| bl_code_i | input | 3 | Burst-length code |
| interleave_i | input | 1 | 1 = interleaved order, 0 = sequential order |
| org_i | input | 2 | Data-width selector that sets the page width |
| write_i | input | 1 | The access being started is a write |
| single_write_i | input | 1 | Limit writes to a single beat |
| col_o | output | COL_W | Column for the current beat |
| valid_o | output | 1 | col_o holds a beat |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
Every output is registered. Beat 0 is therefore due one clock after the edge that samples start_i, and beat i is due i clocks after beat 0. The end of a burst, whether caused by its length or by stop_i, shows on valid_o one clock after the final beat or after the sampled stop. The bench changes inputs on falling edges and samples outputs on the falling edge half a period after each rising edge. The result of a start driven at one falling edge is read at the next falling edge, and each later beat is read one falling edge later.

// File: rtl/burst_col_seq_pkg.sv
package burst_col_seq_pkg;

    localparam int LOG_W = 2;

    typedef enum logic [2:0] {
        BL_ONE   = 3'b000,
        BL_TWO   = 3'b001,
        BL_FOUR  = 3'b010,
        BL_EIGHT = 3'b011,
        BL_PAGE  = 3'b111
    } bl_code_e;

    typedef enum logic [1:0] {
        ORG_X4  = 2'b00,
        ORG_X8  = 2'b01,
        ORG_X16 = 2'b10
    } org_e;

endpackage

// File: rtl/bsq_len_decode.sv
module bsq_len_decode
    import burst_col_seq_pkg::*;
(
    input  logic [2:0]       code_i,
    input  logic             write_i,
    input  logic             single_write_i,
    output logic [LOG_W-1:0] log_len_o,
    output logic             full_o
);
    always_comb begin
        log_len_o = '0;
        full_o    = 1'b0;
        case (code_i)
            BL_TWO:   log_len_o = LOG_W'(1);
            BL_FOUR:  log_len_o = LOG_W'(2);
            BL_EIGHT: log_len_o = LOG_W'(3);
            BL_PAGE:  full_o    = 1'b1;
            default:  log_len_o = '0;
        endcase
        if (write_i && single_write_i) begin
            log_len_o = '0;
            full_o    = 1'b0;
        end
    end

    always_comb begin
        assert_single_write_R7: assert (!(write_i && single_write_i) || (log_len_o == '0 && !full_o));
    end
endmodule

// File: rtl/bsq_page_mask.sv
module bsq_page_mask
    import burst_col_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [1:0]       org_i,
    output logic [COL_W-1:0] mask_o
);
    logic [1:0] drop;

    always_comb begin
        case (org_i)
            ORG_X4:  drop = 2'd0;
            ORG_X8:  drop = 2'd1;
            default: drop = 2'd2;
        endcase
    end

    for (genvar g = 0; g < COL_W; g++) begin : g_bit
        assign mask_o[g] = (g < COL_W - int'(drop));
    end
endmodule

// File: rtl/bsq_col_gen.sv
module bsq_col_gen
    import burst_col_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] idx_i,
    input  logic [LOG_W-1:0] log_len_i,
    input  logic             full_i,
    input  logic             interleave_i,
    input  logic [COL_W-1:0] page_mask_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] low_mask;
    logic [COL_W-1:0] sum;

    for (genvar g = 0; g < COL_W; g++) begin : g_low
        assign low_mask[g] = (g < int'(log_len_i));
    end

    assign sum = base_i + idx_i;

    always_comb begin
        if (full_i)
            col_o = sum & page_mask_i;
        else if (interleave_i)
            col_o = base_i ^ (idx_i & low_mask);
        else
            col_o = (base_i & ~low_mask) | (sum & low_mask);
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_col_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       bl_code_i,
    input  logic             interleave_i,
    input  logic [1:0]       org_i,
    input  logic             write_i,
    input  logic             single_write_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);
    typedef struct packed {
        logic             active;
        logic             full;
        logic             il;
        logic [LOG_W-1:0] log_len;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] cnt;
        logic [COL_W-1:0] col;
        logic             valid;
        logic             last;
    } state_t;

    state_t st_d, st_q;

    logic [LOG_W-1:0] new_log;
    logic             new_full;
    logic [COL_W-1:0] new_mask;
    logic [COL_W-1:0] gen_col;
    logic [COL_W-1:0] cur_low;

    bsq_len_decode u_dec (
        .code_i         (bl_code_i),
        .write_i        (write_i),
        .single_write_i (single_write_i),
        .log_len_o      (new_log),
        .full_o         (new_full)
    );

    bsq_page_mask #(.COL_W(COL_W)) u_mask (
        .org_i  (org_i),
        .mask_o (new_mask)
    );

    bsq_col_gen #(.COL_W(COL_W)) u_gen (
        .base_i       (start_i ? (start_col_i & new_mask) : st_q.base),
        .idx_i        (start_i ? '0 : st_q.cnt),
        .log_len_i    (start_i ? new_log : st_q.log_len),
        .full_i       (start_i ? new_full : st_q.full),
        .interleave_i (start_i ? interleave_i : st_q.il),
        .page_mask_i  (start_i ? new_mask : st_q.mask),
        .col_o        (gen_col)
    );

    assign cur_low = (COL_W'(1) << st_q.log_len) - COL_W'(1);

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.last  = 1'b0;
        st_d.col   = '0;
        if (start_i) begin
            st_d.full    = new_full;
            st_d.il      = interleave_i;
            st_d.log_len = new_log;
            st_d.base    = start_col_i & new_mask;
            st_d.mask    = new_mask;
            st_d.cnt     = COL_W'(1);
            st_d.col     = gen_col;
            st_d.valid   = 1'b1;
            st_d.last    = !new_full && (new_log == '0);
            st_d.active  = !st_d.last;
        end else if (st_q.active && !stop_i) begin
            st_d.col    = gen_col;
            st_d.valid  = 1'b1;
            st_d.last   = !st_q.full && (st_q.cnt == cur_low);
            st_d.active = !st_d.last;
            st_d.cnt    = st_q.cnt + COL_W'(1);
        end else begin
            st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign col_o   = st_q.col;
    assign valid_o = st_q.valid;
    assign last_o  = st_q.last;

    assert_start_gives_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o);
    assert_col_in_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((col_o & ~st_q.mask) == '0));
    assert_end_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);
    assert_last_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);
    assert_page_never_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && st_q.full) |-> !last_o);
    assert_stop_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !valid_o);
    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (col_o == '0));
endmodule

// File: tb/burst_col_seq_test.sv
`timescale 1ns/1ps
module burst_col_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, stop_i = 1'b0;
    logic [9:0] start_col_i = '0;
    logic [2:0] bl_code_i = '0;
    logic       interleave_i = 1'b0;
    logic [1:0] org_i = '0;
    logic       write_i = 1'b0, single_write_i = 1'b0;
    logic [9:0] col_o;
    logic       valid_o, last_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    burst_col_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .start_col_i(start_col_i), .bl_code_i(bl_code_i), .interleave_i(interleave_i),
        .org_i(org_i), .write_i(write_i), .single_write_i(single_write_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    typedef struct packed {
        logic [9:0]      sc;
        logic [2:0]      blc;
        logic            il;
        logic [1:0]      org;
        logic            wr;
        logic            sw;
        logic [3:0]      len;
        logic [0:7][9:0] cols;
    } vec_t;

    localparam vec_t TAB [10] = '{
        '{10'h005, 3'b011, 1'b0, 2'b00, 1'b0, 1'b0, 4'd8, '{10'h005,10'h006,10'h007,10'h000,10'h001,10'h002,10'h003,10'h004}},
        '{10'h005, 3'b011, 1'b1, 2'b00, 1'b0, 1'b0, 4'd8, '{10'h005,10'h004,10'h007,10'h006,10'h001,10'h000,10'h003,10'h002}},
        '{10'h12D, 3'b010, 1'b0, 2'b00, 1'b0, 1'b0, 4'd4, '{10'h12D,10'h12E,10'h12F,10'h12C,10'h0,10'h0,10'h0,10'h0}},
        '{10'h12D, 3'b010, 1'b1, 2'b00, 1'b0, 1'b0, 4'd4, '{10'h12D,10'h12C,10'h12F,10'h12E,10'h0,10'h0,10'h0,10'h0}},
        '{10'h3FF, 3'b001, 1'b0, 2'b01, 1'b0, 1'b0, 4'd2, '{10'h1FF,10'h1FE,10'h0,10'h0,10'h0,10'h0,10'h0,10'h0}},
        '{10'h3FF, 3'b000, 1'b0, 2'b10, 1'b0, 1'b0, 4'd1, '{10'h0FF,10'h0,10'h0,10'h0,10'h0,10'h0,10'h0,10'h0}},
        '{10'h2A3, 3'b100, 1'b0, 2'b00, 1'b0, 1'b0, 4'd1, '{10'h2A3,10'h0,10'h0,10'h0,10'h0,10'h0,10'h0,10'h0}},
        '{10'h010, 3'b011, 1'b0, 2'b00, 1'b1, 1'b1, 4'd1, '{10'h010,10'h0,10'h0,10'h0,10'h0,10'h0,10'h0,10'h0}},
        '{10'h013, 3'b010, 1'b0, 2'b00, 1'b1, 1'b0, 4'd4, '{10'h013,10'h010,10'h011,10'h012,10'h0,10'h0,10'h0,10'h0}},
        '{10'h001, 3'b001, 1'b1, 2'b00, 1'b0, 1'b1, 4'd2, '{10'h001,10'h000,10'h0,10'h0,10'h0,10'h0,10'h0,10'h0}}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic beat(input string req, input logic [9:0] c, input bit lst);
        chk(valid_o === 1'b1, {req, " valid"}, int'(valid_o), 1);
        chk(col_o === c, {req, " col"}, int'(col_o), int'(c));
        chk(last_o === lst, {req, " last"}, int'(last_o), int'(lst));
    endtask

    task automatic idle(input string req);
        chk(valid_o === 1'b0, {req, " idle valid"}, int'(valid_o), 0);
        chk(col_o === 10'h0, {req, " idle col R11"}, int'(col_o), 0);
    endtask

    task automatic fire(input logic [9:0] sc, input logic [2:0] blc, input logic il,
                        input logic [1:0] org, input logic wr, input logic sw);
        start_col_i = sc; bl_code_i = blc; interleave_i = il;
        org_i = org; write_i = wr; single_write_i = sw; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        #1;
        chk(valid_o === 1'b0 && last_o === 1'b0 && col_o === 10'h0, "R1 reset", int'(col_o), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid_o === 1'b0 && last_o === 1'b0 && col_o === 10'h0, "R1 after reset", int'(valid_o), 0);

        // table: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < 10; v++) begin
            fire(TAB[v].sc, TAB[v].blc, TAB[v].il, TAB[v].org, TAB[v].wr, TAB[v].sw);
            for (int i = 0; i < int'(TAB[v].len); i++) begin
                beat($sformatf("R2/R3/R4/R5/R6/R7 vec%0d beat%0d", v, i), TAB[v].cols[i],
                     i == int'(TAB[v].len) - 1);
                @(negedge clk);
            end
            idle($sformatf("R5 vec%0d end", v));
        end

        // R8: full page, interleave ignored, wraps at 8-bit page, no last; R9 stop
        fire(10'h0FE, 3'b111, 1'b1, 2'b10, 1'b0, 1'b0);
        beat("R8 page beat0", 10'h0FE, 1'b0);
        @(negedge clk); beat("R8 page beat1", 10'h0FF, 1'b0);
        @(negedge clk); beat("R8 page wrap", 10'h000, 1'b0);
        @(negedge clk); beat("R8 page beat3", 10'h001, 1'b0);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        idle("R9 stop");

        // R10: abort an 8-beat burst after two beats
        fire(10'h000, 3'b011, 1'b0, 2'b00, 1'b0, 1'b0);
        beat("R10 old beat0", 10'h000, 1'b0);
        @(negedge clk); beat("R10 old beat1", 10'h001, 1'b0);
        fire(10'h042, 3'b001, 1'b0, 2'b00, 1'b0, 1'b0);
        beat("R10 new beat0", 10'h042, 1'b0);
        @(negedge clk); beat("R10 new beat1", 10'h043, 1'b1);
        @(negedge clk); idle("R10 end");

        // R9: start wins over simultaneous stop
        fire(10'h100, 3'b111, 1'b0, 2'b00, 1'b0, 1'b0);
        beat("R9 page beat0", 10'h100, 1'b0);
        stop_i = 1'b1;
        fire(10'h208, 3'b010, 1'b1, 2'b00, 1'b0, 1'b0);
        stop_i = 1'b0;
        beat("R9 start wins beat0", 10'h208, 1'b0);
        @(negedge clk); beat("R9 start wins beat1", 10'h209, 1'b0);
        @(negedge clk); beat("R9 start wins beat2", 10'h20A, 1'b0);
        @(negedge clk); beat("R9 start wins beat3", 10'h20B, 1'b1);
        @(negedge clk); idle("R9 end");

        finish_run();
    end
endmodule